// File: doc/BRIEF.md
# Power-Saving Clock Switchback Controller

This block controls a reduced-rate operating mode. Software sets a power-management flag to run the system clock divided down, and the block drives a divide-select code to the clock divider for as long as the flag is set. A second software bit arms automatic return to full rate. When that bit is set, peripheral activity that needs a quick response clears the flag in hardware, and the divider goes back to the undivided clock. The qualifying activity is serial receive or transmit, SPI transfers, CAN receive activity, enabled external interrupts, and debug entry.

The block qualifies each activity input against its own enables and mode bits. It also detects the falling edge on the asynchronous serial receive line. While return to full rate is armed and any qualified event is present, a software attempt to set the flag has no effect, so software cannot drop the clock in the middle of handling that event.

Top module: `pm_switchback_ctrl`

## Requirements
- R1: After reset, `pm_en`, `sb_en` and `clk_div_sel` are all 0.
- R2: A write (`pm_wr`=1) of `pm_wdata`=1 while no event is blocking sets `pm_en` on the next clock edge. A write of 0 always clears it on the next clock edge. `sb_wr` loads `sb_wdata` into `sb_en` on the next edge. `clk_div_sel` equals `PM_DIV_CODE` (default 4) while `pm_en` is 1, and 0 otherwise. The flag rises only on such a write.
- R3: While `sb_en` is 0, no event input changes `pm_en`, and software writes of 1 take effect.
- R4: External interrupt bit i is an event only when `ext_irq_pend[i]` and `ext_irq_en[i]` are both 1. A pending bit without its enable has no effect.
- R5: A high-to-low transition on `uart_rxd` is an event only when `uart_rx_en`=1 and `uart_mode` is 1, 2 or 3 (mode 0 never qualifies). The line passes through two synchronizer flops and an edge flop, so `pm_en` reads 0 after the third rising clock edge following the fall.
- R6: `uart_tx_wr` is an event only while `uart_tx_en`=1.
- R7: `spi_data_wr` is an event only when `spi_master`=1 and `spi_tx_en`=1. `spi_ss_n`=0 is an event only when `spi_master`=0.
- R8: `can_rx_act` is an event only while `can_irq_en`=1. `dbg_enter`=1 is always an event.
- R9: With `sb_en`=1, any qualified event clears `pm_en` on the next edge. A write of 1 in the same cycle as an event, or while an event persists, is ignored, and the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pm_wr | input | 1 | Software write strobe for the power-management flag |
| pm_wdata | input | 1 | Value written to the power-management flag |
| sb_wr | input | 1 | Software write strobe for the switchback-enable bit |
| sb_wdata | input | 1 | Value written to the switchback-enable bit |
| ext_irq_pend | input | N_EXT | External interrupt conditions |
| ext_irq_en | input | N_EXT | External interrupt enables |
| uart_mode | input | 2 | Serial port mode (0 synchronous, 1..3 asynchronous) |
| uart_rx_en | input | 1 | Serial reception enable |
| uart_rxd | input | 1 | Asynchronous serial receive line |
| uart_tx_en | input | 1 | Serial transmission enable |
| uart_tx_wr | input | 1 | Write pulse to serial transmit data register |
| spi_master | input | 1 | SPI master mode (1) or slave mode (0) |
| spi_tx_en | input | 1 | SPI transmission enable |
| spi_data_wr | input | 1 | Write pulse to SPI data register |
| spi_ss_n | input | 1 | SPI slave select, active low |
| can_rx_act | input | 1 | CAN receive-line activity |
| can_irq_en | input | 1 | CAN activity interrupt enable |
| dbg_enter | input | 1 | Debug mode entry pulse |
| pm_en | output | 1 | Power-management flag |
| sb_en | output | 1 | Switchback-enable bit |
| clk_div_sel | output | DIV_W | Divide-select code to the clock divider |

## Verification
The assertions assume that every event input other than `uart_rxd` is already synchronous to `clk`. They also assume that the inputs hold their reset-idle values while reset is applied: `uart_rxd` and `spi_ss_n` high, everything else low. The bench changes inputs only on the falling clock edge and keeps both idle-high lines high during reset. It moves `uart_rxd` low only after the flags are programmed, and it waits out the three-stage receive path before it applies new stimulus. Each event is tested once with its qualifier off and once with it on, and every event is removed before the flag is set again.

// File: rtl/pmsb_pkg.sv
package pmsb_pkg;

    localparam int SRC_EXT  = 0;
    localparam int SRC_URX  = 1;
    localparam int SRC_UTX  = 2;
    localparam int SRC_SPIW = 3;
    localparam int SRC_SPSS = 4;
    localparam int SRC_CAN  = 5;
    localparam int SRC_DBG  = 6;
    localparam int SRC_N    = 7;

    typedef enum logic [1:0] {
        UMODE_SYNC   = 2'd0,
        UMODE_ASYNC8 = 2'd1,
        UMODE_ASYNCA = 2'd2,
        UMODE_ASYNCB = 2'd3
    } uart_mode_e;

    typedef struct packed {
        logic pm_en;
        logic sb_en;
    } ctl_state_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } rx_sync_t;

endpackage

// File: rtl/pmsb_rx_fall.sv
module pmsb_rx_fall
    import pmsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_async,
    output logic fall
);

    rx_sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = rxd_async;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    assign fall = st_q.prev & ~st_q.s2;

    // R5
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/pmsb_src_qual.sv
module pmsb_src_qual
    import pmsb_pkg::*;
#(
    parameter int N_EXT = 8
) (
    input  logic [N_EXT-1:0] ext_irq_pend,
    input  logic [N_EXT-1:0] ext_irq_en,
    input  logic [1:0]       uart_mode,
    input  logic             uart_rx_en,
    input  logic             rx_fall,
    input  logic             uart_tx_en,
    input  logic             uart_tx_wr,
    input  logic             spi_master,
    input  logic             spi_tx_en,
    input  logic             spi_data_wr,
    input  logic             spi_ss_n,
    input  logic             can_rx_act,
    input  logic             can_irq_en,
    input  logic             dbg_enter,
    output logic [SRC_N-1:0] src_vec,
    output logic             src_any
);

    logic [N_EXT-1:0] ext_hit;
    logic             uart_async;

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_ext
            assign ext_hit[gi] = ext_irq_pend[gi] & ext_irq_en[gi];
        end
    endgenerate

    always_comb begin
        uart_async         = (uart_mode != UMODE_SYNC);
        src_vec            = '0;
        src_vec[SRC_EXT]   = |ext_hit;
        src_vec[SRC_URX]   = rx_fall & uart_rx_en & uart_async;
        src_vec[SRC_UTX]   = uart_tx_wr & uart_tx_en;
        src_vec[SRC_SPIW]  = spi_data_wr & spi_master & spi_tx_en;
        src_vec[SRC_SPSS]  = ~spi_ss_n & ~spi_master;
        src_vec[SRC_CAN]   = can_rx_act & can_irq_en;
        src_vec[SRC_DBG]   = dbg_enter;
        src_any            = |src_vec;
    end

endmodule

// File: rtl/pm_switchback_ctrl.sv
module pm_switchback_ctrl
    import pmsb_pkg::*;
#(
    parameter int               N_EXT       = 8,
    parameter int               DIV_W       = 3,
    parameter logic [DIV_W-1:0] PM_DIV_CODE = 3'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pm_wr,
    input  logic             pm_wdata,
    input  logic             sb_wr,
    input  logic             sb_wdata,
    input  logic [N_EXT-1:0] ext_irq_pend,
    input  logic [N_EXT-1:0] ext_irq_en,
    input  logic [1:0]       uart_mode,
    input  logic             uart_rx_en,
    input  logic             uart_rxd,
    input  logic             uart_tx_en,
    input  logic             uart_tx_wr,
    input  logic             spi_master,
    input  logic             spi_tx_en,
    input  logic             spi_data_wr,
    input  logic             spi_ss_n,
    input  logic             can_rx_act,
    input  logic             can_irq_en,
    input  logic             dbg_enter,
    output logic             pm_en,
    output logic             sb_en,
    output logic [DIV_W-1:0] clk_div_sel
);

    ctl_state_t       st_d, st_q;
    logic             rx_fall;
    logic [SRC_N-1:0] src_vec;
    logic             src_any;
    logic             force_full;

    pmsb_rx_fall u_rx_fall (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd_async (uart_rxd),
        .fall      (rx_fall)
    );

    pmsb_src_qual #(.N_EXT(N_EXT)) u_qual (
        .ext_irq_pend (ext_irq_pend),
        .ext_irq_en   (ext_irq_en),
        .uart_mode    (uart_mode),
        .uart_rx_en   (uart_rx_en),
        .rx_fall      (rx_fall),
        .uart_tx_en   (uart_tx_en),
        .uart_tx_wr   (uart_tx_wr),
        .spi_master   (spi_master),
        .spi_tx_en    (spi_tx_en),
        .spi_data_wr  (spi_data_wr),
        .spi_ss_n     (spi_ss_n),
        .can_rx_act   (can_rx_act),
        .can_irq_en   (can_irq_en),
        .dbg_enter    (dbg_enter),
        .src_vec      (src_vec),
        .src_any      (src_any)
    );

    always_comb begin
        st_d       = st_q;
        force_full = st_q.sb_en & src_any;
        if (sb_wr) st_d.sb_en = sb_wdata;
        if (pm_wr && !pm_wdata)        st_d.pm_en = 1'b0;
        else if (pm_wr && !force_full) st_d.pm_en = 1'b1;
        if (force_full)                st_d.pm_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pm_en       = st_q.pm_en;
    assign sb_en       = st_q.sb_en;
    assign clk_div_sel = st_q.pm_en ? PM_DIV_CODE : '0;

    // R2
    pm_rise_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_en) |-> $past(pm_wr && pm_wdata));

    // R2
    pm_clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_wr && !pm_wdata) |=> !pm_en);

    // R3
    sb_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sb_en && !pm_wr) |=> $stable(pm_en));

    // R9
    switchback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_en && (|src_vec)) |=> !pm_en);

endmodule

// File: tb/pm_switchback_ctrl_tb.sv
`timescale 1ns/1ps
module pm_switchback_ctrl_tb;

    localparam int N_EXT = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic pm_wr, pm_wdata, sb_wr, sb_wdata;
    logic [N_EXT-1:0] ext_irq_pend, ext_irq_en;
    logic [1:0] uart_mode;
    logic uart_rx_en, uart_rxd, uart_tx_en, uart_tx_wr;
    logic spi_master, spi_tx_en, spi_data_wr, spi_ss_n;
    logic can_rx_act, can_irq_en, dbg_enter;
    logic pm_en, sb_en;
    logic [2:0] clk_div_sel;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  pm;
        logic  sb;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pm_switchback_ctrl #(.N_EXT(N_EXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_wdata(pm_wdata),
        .sb_wr(sb_wr), .sb_wdata(sb_wdata), .ext_irq_pend(ext_irq_pend),
        .ext_irq_en(ext_irq_en), .uart_mode(uart_mode), .uart_rx_en(uart_rx_en),
        .uart_rxd(uart_rxd), .uart_tx_en(uart_tx_en), .uart_tx_wr(uart_tx_wr),
        .spi_master(spi_master), .spi_tx_en(spi_tx_en), .spi_data_wr(spi_data_wr),
        .spi_ss_n(spi_ss_n), .can_rx_act(can_rx_act), .can_irq_en(can_irq_en),
        .dbg_enter(dbg_enter), .pm_en(pm_en), .sb_en(sb_en), .clk_div_sel(clk_div_sel)
    );

    task automatic compare(input logic ep, input logic es, input string req);
        logic [2:0] ed;
        ed = ep ? 3'd4 : 3'd0;
        checks++;
        if (pm_en !== ep || sb_en !== es || clk_div_sel !== ed) begin
            fails++;
            $display("FAIL %s: pm_en=%b sb_en=%b div=%0d expected pm_en=%b sb_en=%b div=%0d",
                     req, pm_en, sb_en, clk_div_sel, ep, es, ed);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compare(e.pm, e.sb, e.req);
        end
    end

    task automatic tick(input logic ep, input logic es, input string req);
        @(posedge clk);
        exp_q.push_back('{pm: ep, sb: es, req: req});
        @(negedge clk);
    endtask

    task automatic wr_pm(input logic v, input logic ep, input logic es, input string req);
        pm_wr = 1'b1; pm_wdata = v;
        tick(ep, es, req);
        pm_wr = 1'b0; pm_wdata = 1'b0;
    endtask

    task automatic wr_sb(input logic v, input logic ep, input string req);
        sb_wr = 1'b1; sb_wdata = v;
        tick(ep, v, req);
        sb_wr = 1'b0; sb_wdata = 1'b0;
    endtask

    task automatic idle_inputs();
        pm_wr = 0; pm_wdata = 0; sb_wr = 0; sb_wdata = 0;
        ext_irq_pend = '0; ext_irq_en = '0;
        uart_mode = 2'd0; uart_rx_en = 0; uart_rxd = 1; uart_tx_en = 0; uart_tx_wr = 0;
        spi_master = 0; spi_tx_en = 0; spi_data_wr = 0; spi_ss_n = 1;
        can_rx_act = 0; can_irq_en = 0; dbg_enter = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        compare(1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(1'b0, 1'b0, "R1 after reset");

        // R2 basic writes
        wr_pm(1, 1, 0, "R2 set");
        tick(1, 0, "R2 hold");
        wr_pm(0, 0, 0, "R2 clear");
        wr_pm(1, 1, 0, "R2 set again");

        // R3 sources with switchback disabled
        ext_irq_pend = 8'h01; ext_irq_en = 8'h01; dbg_enter = 1;
        uart_tx_en = 1; uart_tx_wr = 1;
        tick(1, 0, "R3 sources ignored");
        wr_pm(1, 1, 0, "R3 write 1 with source, sb off");
        idle_inputs();

        wr_sb(1, 1, "R2 sb set");

        // R4
        ext_irq_pend = 8'h20; ext_irq_en = 8'h10;
        tick(1, 1, "R4 pend without enable");
        ext_irq_en = 8'h30;
        tick(0, 1, "R4 enabled ext irq");
        idle_inputs();
        wr_pm(1, 1, 1, "R4 restore");

        // R6
        uart_tx_wr = 1;
        tick(1, 1, "R6 tx write no enable");
        uart_tx_en = 1;
        tick(0, 1, "R6 tx write enabled");
        idle_inputs();
        wr_pm(1, 1, 1, "R6 restore");

        // R7
        spi_tx_en = 1; spi_data_wr = 1; spi_master = 0;
        tick(1, 1, "R7 spi write in slave mode");
        spi_master = 1;
        tick(0, 1, "R7 spi write master");
        idle_inputs();
        wr_pm(1, 1, 1, "R7 restore");
        spi_master = 1; spi_ss_n = 0;
        tick(1, 1, "R7 ss low in master mode");
        spi_master = 0;
        tick(0, 1, "R7 ss low slave mode");
        idle_inputs();
        wr_pm(1, 1, 1, "R7 restore ss");

        // R8
        can_rx_act = 1;
        tick(1, 1, "R8 can act no enable");
        can_irq_en = 1;
        tick(0, 1, "R8 can act enabled");
        idle_inputs();
        wr_pm(1, 1, 1, "R8 restore");
        dbg_enter = 1;
        tick(0, 1, "R8 debug entry");
        idle_inputs();
        wr_pm(1, 1, 1, "R8 restore dbg");

        // R5 mode 0 does not qualify
        uart_mode = 2'd0; uart_rx_en = 1; uart_rxd = 0;
        for (int i = 0; i < 4; i++) tick(1, 1, "R5 mode0 fall ignored");
        uart_rxd = 1;
        for (int i = 0; i < 4; i++) tick(1, 1, "R5 rise ignored");
        // R5 mode 2 qualifies, latency three edges
        uart_mode = 2'd2; uart_rxd = 0;
        tick(1, 1, "R5 edge 1");
        tick(1, 1, "R5 edge 2");
        tick(0, 1, "R5 edge 3 cleared");
        tick(0, 1, "R5 stays clear");
        uart_rxd = 1;
        for (int i = 0; i < 4; i++) tick(0, 1, "R5 rise no effect");
        wr_pm(1, 1, 1, "R5 restore");
        uart_mode = 2'd1; uart_rx_en = 0; uart_rxd = 0;
        for (int i = 0; i < 4; i++) tick(1, 1, "R5 rx disabled ignored");
        uart_rxd = 1;
        for (int i = 0; i < 4; i++) tick(1, 1, "R5 settle");
        idle_inputs();

        // R9 clear wins and writes blocked
        ext_irq_pend = 8'h80; ext_irq_en = 8'h80;
        wr_pm(1, 0, 1, "R9 same-cycle clear wins");
        wr_pm(1, 0, 1, "R9 write blocked while pending");
        tick(0, 1, "R9 hold");
        idle_inputs();
        wr_pm(1, 1, 1, "R9 write accepted after source gone");
        wr_pm(0, 0, 1, "R2 clear with sb on");

        @(negedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule